// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous on-chip requester and an external asynchronous static RAM of 2^19 words by 32 bits. The RAM has four active-low byte-lane enables, one active-low write strobe and one active-low output enable. A request names a logical address, write data, a four-bit byte mask and a direction. The controller drives the strobes in a fixed cycle pattern, holds address and data steady for the whole access, and returns read data as a one-cycle response pulse.

All timing is given in picoseconds as parameters. Each value is turned into a count of system-clock cycles by rounding up, and a count is never less than one. Write length is the larger of the strobe-width count and the data-setup count. Read length is the access-time count. After every access there is a fixed idle gap, so the data bus is released before any later output enable falls.

An organisation input chooses how the logical address space is seen: 32-bit words, 16-bit halfwords or 8-bit bytes over the same array. In the narrow modes, the low logical address bits choose which lane enables fire. Back-pressure works only on the request side. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` depends only on internal state, never on `req_valid`. The response has no ready input, and the requester must take `rsp_valid` in the cycle it is shown.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released: `req_ready` is 1, all four enables are high, the write strobe and output enable are high, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the access and its idle gap have finished.
- R3: A write drives the write strobe low starting in the cycle after acceptance, for WR_CYC cycles (2 with default parameters). `mem_dq_oe` is high in exactly those cycles, output enable stays high, and address and write data do not change while the strobe is low.
- R4: A read drives output enable low starting in the cycle after acceptance, for RD_CYC cycles (3 by default). The bus is sampled at the last edge of that window. `rsp_valid` is then high for exactly one cycle, carrying the sampled data.
- R5: After every access, TURN_CYC cycles (1 by default) follow with every strobe inactive and `req_ready` low, and `req_ready` rises in the cycle after that. The controller never has `mem_dq_oe` high while output enable is low.
- R6: With `org_mode`=0 (32-bit), `mem_addr` is logical address bits 18:0. Lane i (data bits 8i+7:8i) is enabled when mask bit i is 1.
- R7: With `org_mode`=1 (16-bit), `mem_addr` is logical bits 19:1. Logical bit 0 = 0 picks lanes 0 and 1, and bit 0 = 1 picks lanes 2 and 3, gated by mask bits 1:0. Write data bits 15:0 go to the chosen half. A read returns that half in bits 15:0 with the upper bits zero.
- R8: With `org_mode`=2 (8-bit), `mem_addr` is logical bits 20:2. Lane number = logical bits 1:0, and that lane is enabled when mask bit 0 is 1. Write data bits 7:0 go to that lane. A read returns the lane in bits 7:0 with the rest zero.
- R9: Mask bits outside the selected width have no effect. A write whose effective mask is empty leaves memory unchanged.
- R10: `org_mode`=3 behaves exactly like 32-bit mode.
- R11: `org_mode` is sampled only at acceptance. Changing it during an access does not change that access or its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| org_mode | input | 2 | Logical organisation: 0=32-bit, 1=16-bit, 2=8-bit, 3=32-bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Logical address |
| req_wdata | input | 32 | Write data, right-aligned in narrow modes |
| req_mask | input | 4 | Byte mask, low bits used in narrow modes |
| rsp_valid | output | 1 | One-cycle pulse: read data present |
| rsp_data | output | 32 | Read data, right-aligned |
| mem_addr | output | 19 | RAM address |
| mem_ce_n | output | 4 | Active-low lane enables, bit i for data bits 8i+7:8i |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 32 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 32 | Data from the RAM |

## Verification
Full-word writes and reads are mixed with sparse byte masks and an all-zero mask. This separates correct per-lane enabling from whole-word writes and shows that an empty mask touches nothing. Halfword and byte accesses are written with their upper mask bits set to junk, then read back both narrow and as whole words, which tells a wrong lane choice apart from a wrong read shift. A read whose mode is flipped after acceptance, plus mode 3 at the top address, shows whether the mode is sampled only at acceptance. Cycle-exact strobe sampling on every access, together with a bus-fight monitor, covers the pulse lengths and the idle gap.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ORG_W32 = 2'd0,
    ORG_W16 = 2'd1,
    ORG_W8  = 2'd2,
    ORG_RSV = 2'd3
  } org_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_GAP
  } seq_st_e;

  // round a time up to whole clock cycles, never below one
  function automatic int unsigned span_cycles(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES   = DATA_W / 8,
  localparam int unsigned SEL_W   = $clog2(LANES),
  localparam int unsigned LADDR_W = ADDR_W + SEL_W
) (
  input  org_e               org,
  input  logic [LADDR_W-1:0] laddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [LANES-1:0]   mask,
  output logic [ADDR_W-1:0]  phys,
  output logic [LANES-1:0]   lane_en,
  output logic [DATA_W-1:0]  lane_wd,
  output logic [SEL_W-1:0]   sel
);
  localparam int unsigned HL   = LANES / 2;
  localparam int unsigned HALF = DATA_W / 2;

  assign sel = laddr[SEL_W-1:0];

  always_comb begin
    phys    = laddr[ADDR_W-1:0];
    lane_en = mask;
    lane_wd = wdata;
    unique case (org)
      ORG_W16: begin
        phys    = laddr[ADDR_W:1];
        lane_wd = {2{wdata[HALF-1:0]}};
        for (int i = 0; i < LANES; i++)
          lane_en[i] = ((i / HL) == int'(laddr[0])) && mask[i % HL];
      end
      ORG_W8: begin
        phys    = laddr[LADDR_W-1:SEL_W];
        lane_wd = {LANES{wdata[7:0]}};
        for (int i = 0; i < LANES; i++)
          lane_en[i] = (i == int'(laddr[SEL_W-1:0])) && mask[0];
      end
      default: begin
        phys    = laddr[ADDR_W-1:0];
        lane_en = mask;
        lane_wd = wdata;
      end
    endcase
  end
endmodule

// File: rtl/sram_rd_align.sv
module sram_rd_align
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned SEL_W = $clog2(LANES)
) (
  input  org_e              org,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] dq,
  output logic [DATA_W-1:0] rd
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [7:0] lane_b [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_b[g] = dq[8*g +: 8];
  end

  always_comb begin
    rd = dq;
    unique case (org)
      ORG_W16: rd = sel[0] ? {{HALF{1'b0}}, dq[DATA_W-1:HALF]}
                           : {{HALF{1'b0}}, dq[HALF-1:0]};
      ORG_W8:  rd = {{(DATA_W-8){1'b0}}, lane_b[sel]};
      default: rd = dq;
    endcase
  end
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned WR_CYC   = 2,
  parameter int unsigned RD_CYC   = 3,
  parameter int unsigned TURN_CYC = 1,
  localparam int unsigned MAX_A   = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC,
  localparam int unsigned MAX_C   = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC,
  localparam int unsigned CNT_W   = $clog2(MAX_C + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_write,
  output logic ready,
  output logic wr_act,
  output logic rd_act,
  output logic capture
);
  seq_st_e st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st  <= start_write ? ST_WRITE : ST_READ;
          cnt <= start_write ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
        end
        ST_WRITE, ST_READ: begin
          if (cnt == '0) begin
            st  <= ST_GAP;
            cnt <= CNT_W'(TURN_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) st <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  assign ready   = (st == ST_IDLE);
  assign wr_act  = (st == ST_WRITE);
  assign rd_act  = (st == ST_READ);
  assign capture = (st == ST_READ) && (cnt == '0);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CLK_PS    = 5000,
  parameter int unsigned T_WP_PS   = 8000,
  parameter int unsigned T_DS_PS   = 6000,
  parameter int unsigned T_AA_PS   = 12000,
  parameter int unsigned T_TURN_PS = 1000,
  localparam int unsigned LANES    = DATA_W / 8,
  localparam int unsigned SEL_W    = $clog2(LANES),
  localparam int unsigned LADDR_W  = ADDR_W + SEL_W,
  localparam int unsigned WP_C     = span_cycles(T_WP_PS, CLK_PS),
  localparam int unsigned DS_C     = span_cycles(T_DS_PS, CLK_PS),
  localparam int unsigned WR_CYC   = (WP_C > DS_C) ? WP_C : DS_C,
  localparam int unsigned RD_CYC   = span_cycles(T_AA_PS, CLK_PS),
  localparam int unsigned TURN_CYC = span_cycles(T_TURN_PS, CLK_PS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         org_mode,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [LADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [LANES-1:0]   req_mask,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [LANES-1:0]   mem_ce_n,
  output logic               mem_we_n,
  output logic               mem_oe_n,
  output logic [DATA_W-1:0]  mem_dq_out,
  output logic               mem_dq_oe,
  input  logic [DATA_W-1:0]  mem_dq_in
);
  logic              take;
  logic              wr_act, rd_act, capture;
  logic [ADDR_W-1:0] m_phys;
  logic [LANES-1:0]  m_en;
  logic [DATA_W-1:0] m_wd;
  logic [SEL_W-1:0]  m_sel;
  logic [DATA_W-1:0] rd_al;

  logic [ADDR_W-1:0] a_q;
  logic [LANES-1:0]  en_q;
  logic [DATA_W-1:0] wd_q;
  logic [SEL_W-1:0]  sel_q;
  org_e              org_q;

  assign take = req_valid && req_ready;

  sram_lane_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map (
    .org     (org_e'(org_mode)),
    .laddr   (req_addr),
    .wdata   (req_wdata),
    .mask    (req_mask),
    .phys    (m_phys),
    .lane_en (m_en),
    .lane_wd (m_wd),
    .sel     (m_sel)
  );

  sram_seq_fsm #(.WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (take),
    .start_write (req_write),
    .ready       (req_ready),
    .wr_act      (wr_act),
    .rd_act      (rd_act),
    .capture     (capture)
  );

  sram_rd_align #(.DATA_W(DATA_W)) u_align (
    .org (org_q),
    .sel (sel_q),
    .dq  (mem_dq_in),
    .rd  (rd_al)
  );

  // hold the mapped request for the whole access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      en_q  <= '0;
      wd_q  <= '0;
      sel_q <= '0;
      org_q <= ORG_W32;
    end else if (take) begin
      a_q   <= m_phys;
      en_q  <= m_en;
      wd_q  <= m_wd;
      sel_q <= m_sel;
      org_q <= org_e'(org_mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_data <= rd_al;
    end
  end

  assign mem_addr   = a_q;
  assign mem_ce_n   = (wr_act || rd_act) ? ~en_q : '1;
  assign mem_we_n   = ~wr_act;
  assign mem_oe_n   = ~rd_act;
  assign mem_dq_oe  = wr_act;
  assign mem_dq_out = wd_q;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WR_CYC = 2,
  parameter int unsigned RD_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  logic [7:0] we_lo, oe_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo <= '0;
      oe_lo <= '0;
    end else begin
      we_lo <= mem_we_n ? 8'd0 : we_lo + 8'd1;
      oe_lo <= mem_oe_n ? 8'd0 : oe_lo + 8'd1;
    end
  end

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> !req_ready);

  assert_write_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (!mem_we_n && mem_oe_n));

  assert_addr_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  assert_wr_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo == 8'(WR_CYC)));

  assert_read_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> !mem_oe_n);

  assert_rd_window_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_lo == 8'(RD_CYC)));

  assert_rsp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n));

  assert_no_bus_fight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  assert_released_before_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  org_mode = 2'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [18:0] mem_addr;
  logic [3:0]  mem_ce_n;
  logic        mem_we_n, mem_oe_n, mem_dq_oe;
  logic [31:0] mem_dq_out;
  logic [31:0] mem_dq_in = 32'hEEEE_EEEE;

  int checks = 0;
  int bad = 0;
  int fights = 0;
  logic [31:0] model [int unsigned];

  always #2.5 clk = ~clk;

  sram_ctrl u_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .org_mode(org_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  function automatic logic [31:0] mword(input int unsigned a);
    return model.exists(a) ? model[a] : 32'h0;
  endfunction

  // behavioural RAM, evaluated away from the active edge
  always @(negedge clk) begin
    logic [31:0] w;
    if (rst_n && !mem_we_n) begin
      w = mword(int'(mem_addr));
      for (int i = 0; i < 4; i++)
        if (!mem_ce_n[i]) w[8*i +: 8] = mem_dq_out[8*i +: 8];
      model[int'(mem_addr)] = w;
    end
    if (mem_dq_oe && !mem_oe_n) fights++;
    if (!mem_oe_n && mem_we_n) begin
      w = mword(int'(mem_addr));
      for (int i = 0; i < 4; i++)
        mem_dq_in[8*i +: 8] = mem_ce_n[i] ? 8'hEE : w[8*i +: 8];
    end else begin
      mem_dq_in = 32'hEEEE_EEEE;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_en(input logic [1:0] org, input logic [20:0] la,
                                        input logic [3:0] mk);
    case (org)
      2'd1: return la[0] ? {mk[1:0], 2'b00} : {2'b00, mk[1:0]};
      2'd2: return mk[0] ? (4'b0001 << la[1:0]) : 4'b0000;
      default: return mk;
    endcase
  endfunction

  function automatic logic [18:0] exp_pa(input logic [1:0] org, input logic [20:0] la);
    case (org)
      2'd1: return la[19:1];
      2'd2: return la[20:2];
      default: return la[18:0];
    endcase
  endfunction

  task automatic access(input bit wr, input logic [1:0] org, input logic [1:0] org_after,
                        input logic [20:0] la, input logic [31:0] wd, input logic [3:0] mk,
                        input string tag, output logic [31:0] rd);
    rd = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    org_mode = org; req_write = wr; req_addr = la; req_wdata = wd; req_mask = mk;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    org_mode = org_after;
    chk(!req_ready, "R2", "ready during access", 32'(req_ready), 0);
    chk(mem_addr == exp_pa(org, la), tag, "mem_addr", 32'(mem_addr), 32'(exp_pa(org, la)));
    chk(mem_ce_n == ~exp_en(org, la, mk), tag, "lane enables", 32'(mem_ce_n),
        32'(~exp_en(org, la, mk)));
    if (wr) begin
      chk(!mem_we_n && mem_oe_n && mem_dq_oe, "R3", "first write cycle",
          {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b011);
      @(negedge clk);
      chk(!mem_we_n && mem_dq_oe, "R3", "second write cycle", {mem_we_n, mem_dq_oe}, 2'b01);
      @(negedge clk);
      chk(mem_we_n && !mem_dq_oe && !req_ready && (mem_ce_n == 4'hF), "R5", "gap after write",
          {mem_we_n, mem_dq_oe, req_ready, mem_ce_n}, 7'b1000000 | 7'h0F);
      @(negedge clk);
      chk(req_ready, "R5", "ready after write gap", 32'(req_ready), 1);
    end else begin
      for (int c = 0; c < 3; c++) begin
        chk(!mem_oe_n && mem_we_n && !rsp_valid, "R4", "read window",
            {mem_oe_n, mem_we_n, rsp_valid}, 3'b010);
        @(negedge clk);
      end
      chk(rsp_valid && mem_oe_n && !req_ready, "R4", "response pulse",
          {rsp_valid, mem_oe_n, req_ready}, 3'b110);
      rd = rsp_data;
      @(negedge clk);
      chk(req_ready && !rsp_valid, "R5", "ready after read gap", {req_ready, rsp_valid}, 2'b10);
    end
  endtask

  task automatic t_reset;
    chk(req_ready && (mem_ce_n == 4'hF) && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
        "R1", "reset state", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid},
        {1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0});
  endtask

  task automatic t_word_and_masks;
    logic [31:0] r;
    access(1, 0, 0, 21'h00123, 32'hA5A5_0F0F, 4'hF, "R6", r);
    access(0, 0, 0, 21'h00123, 0, 4'hF, "R6", r);
    chk(r == 32'hA5A5_0F0F, "R6", "full word readback", r, 32'hA5A5_0F0F);
    access(1, 0, 0, 21'h00123, 32'h1122_3344, 4'b1010, "R6", r);
    access(0, 0, 0, 21'h00123, 0, 4'hF, "R6", r);
    chk(r == 32'h11A5_330F, "R6", "sparse mask merge", r, 32'h11A5_330F);
    access(1, 0, 0, 21'h00123, 32'hFFFF_FFFF, 4'h0, "R9", r);
    access(0, 0, 0, 21'h00123, 0, 4'hF, "R9", r);
    chk(r == 32'h11A5_330F, "R9", "empty mask leaves word", r, 32'h11A5_330F);
  endtask

  task automatic t_half;
    logic [31:0] r;
    logic [18:0] p = 19'h00456;
    access(1, 1, 1, {1'b0, p, 1'b1}, 32'h1234_BEEF, 4'hF, "R7", r);
    access(1, 1, 1, {1'b0, p, 1'b0}, 32'h0000_CAFE, 4'b1101, "R7", r);
    access(0, 0, 0, {2'b00, p}, 0, 4'hF, "R9", r);
    chk(r == 32'hBEEF_00FE, "R9", "half writes ignore upper mask", r, 32'hBEEF_00FE);
    access(0, 1, 1, {1'b0, p, 1'b1}, 0, 4'h3, "R7", r);
    chk(r == 32'h0000_BEEF, "R7", "upper half read", r, 32'h0000_BEEF);
    access(0, 1, 1, {1'b0, p, 1'b0}, 0, 4'h3, "R7", r);
    chk(r == 32'h0000_00FE, "R7", "lower half read", r, 32'h0000_00FE);
  endtask

  task automatic t_byte;
    logic [31:0] r;
    logic [18:0] q = 19'h07ABC;
    for (int i = 0; i < 4; i++)
      access(1, 2, 2, {q, 2'(i)}, 32'hFFFF_FF10 + 32'(i), 4'b0001, "R8", r);
    access(1, 2, 2, {q, 2'd1}, 32'h0000_0077, 4'b1110, "R9", r);
    access(0, 0, 0, {2'b00, q}, 0, 4'hF, "R8", r);
    chk(r == 32'h1312_1110, "R8", "bytes assembled in lanes", r, 32'h1312_1110);
    access(0, 2, 2, {q, 2'd2}, 0, 4'h1, "R8", r);
    chk(r == 32'h0000_0012, "R8", "byte read lane 2", r, 32'h0000_0012);
  endtask

  task automatic t_reserved_mode;
    logic [31:0] r;
    access(1, 3, 3, 21'h07FFFF, 32'hDEAD_BEEF, 4'hF, "R10", r);
    access(0, 0, 0, 21'h07FFFF, 0, 4'hF, "R10", r);
    chk(r == 32'hDEAD_BEEF, "R10", "mode 3 acts as word mode", r, 32'hDEAD_BEEF);
  endtask

  task automatic t_mode_change;
    logic [31:0] r;
    access(0, 2, 0, {19'h07ABC, 2'd3}, 0, 4'h1, "R11", r);
    chk(r == 32'h0000_0013, "R11", "mode flipped mid-read", r, 32'h0000_0013);
  endtask

  task automatic t_turnaround;
    logic [31:0] r;
    access(1, 0, 0, 21'h00200, 32'h0BAD_F00D, 4'hF, "R5", r);
    access(0, 0, 0, 21'h00200, 0, 4'hF, "R5", r);
    chk(r == 32'h0BAD_F00D, "R5", "write then read", r, 32'h0BAD_F00D);
    chk(fights == 0, "R5", "bus fight cycles", fights, 0);
  endtask

  bit done = 1'b0;

  initial begin
    #100000;
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog run hung actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_and_masks();
    t_half();
    t_byte();
    t_reserved_mode();
    t_mode_change();
    t_turnaround();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule